// File: doc/BRIEF.md
# Message Time Stamp Counter

This block keeps a free-running time base for a CAN controller and hands a stamp to the message store each time a frame finishes. The counter advances on a divided form of the CAN bit clock. A two-bit prescale select picks the divisor: 1, 2, 3 or 4 bit-clock ticks per count. The count runs only while the controller's two module-reset control bits are both clear.

On each completed frame the block samples the current count and presents it with a one-cycle valid pulse, so the slot write logic can store it. In normal operation both sent and received frames are stamped. In loopback operation only a received frame gets a stamp, and only when a data-frame or remote-frame slot is free to take it. Software can clear the count with a dedicated strobe, or by putting the controller into full reset.

Top module: `msg_stamp_timer`

## Requirements
- R1: After the asynchronous reset `stamp` reads 0x0000, `cap_valid` reads 0 and the prescale divider is empty.
- R2: `pre_sel` picks the divisor: 2'b00 counts every `bit_tick`, 2'b01 every second, 2'b10 every third and 2'b11 every fourth. `stamp` changes one clock after the tick that completes a divide period.
- R3: `stamp` and the divider advance only while `mod_rst` is 2'b00. With `mod_rst` at 2'b01 or 2'b10 they hold their values.
- R4: The count event that follows 0xFFFF takes `stamp` to 0x0000.
- R5: While `mod_rst` is 2'b11, `stamp` and the divider are cleared, one clock after that value is seen.
- R6: A high `sw_clr` clears `stamp` and the divider one clock later. It wins over a count event in the same cycle.
- R7: After any clear, the first increment comes only after a full divide period of ticks has been counted from zero.
- R8: With `loopback` low, a `tx_done` or `rx_done` pulse raises `cap_valid` one clock later. `cap_stamp` then carries the `stamp` value of the pulse cycle, and `slot_free` has no effect.
- R9: With `loopback` high, `cap_valid` rises only for `rx_done` together with `slot_free`. A `tx_done` alone, or an `rx_done` without a free slot, gives no pulse.
- R10: `cap_valid` is high for exactly one cycle per qualifying completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per CAN bit clock period |
| pre_sel | input | 2 | Divisor select: 00=/1, 01=/2, 10=/3, 11=/4 |
| mod_rst | input | 2 | Module reset control bits: 00 runs, 11 clears, others hold |
| sw_clr | input | 1 | Software counter clear strobe |
| loopback | input | 1 | Loopback operation flag |
| tx_done | input | 1 | Transmit completion pulse |
| rx_done | input | 1 | Receive completion pulse |
| slot_free | input | 1 | A receive slot is available (loopback only) |
| stamp | output | 16 | Current count value |
| cap_valid | output | 1 | Capture pulse toward the slot store |
| cap_stamp | output | 16 | Stamp value that goes with `cap_valid` |

## Verification
Every result is due one clock after the cycle whose inputs cause it. A tick that completes a divide period, a clear or a reset-bit value shows on `stamp` after the next edge. A completion pulse shows on `cap_valid` and `cap_stamp` after the next edge, with the stamp taken from before that edge. The bench drives inputs on falling edges. A behavioural model steps on every rising edge from the same inputs, and the outputs are compared on the following falling edge. Directed checks record `stamp` in the pulse cycle and look one cycle later, and they count ticks from a clear to find the first increment.

// File: rtl/msg_stamp_pkg.sv
package msg_stamp_pkg;
  localparam int STAMP_W = 16;
  localparam int SEL_W   = 2;
  localparam int RST_W   = 2;

  // module reset control encodings
  localparam logic [RST_W-1:0] MODE_RUN  = '0;
  localparam logic [RST_W-1:0] MODE_HALT = '1;

  typedef enum logic [1:0] {
    CAP_NONE = 2'b00,
    CAP_TX   = 2'b01,
    CAP_RX   = 2'b10,
    CAP_BOTH = 2'b11
  } cap_src_e;
endpackage

// File: rtl/msg_stamp_presc.sv
module msg_stamp_presc #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             evt
);
  logic [SEL_W-1:0] div_q, div_d;
  logic             div_en;

  // event on the tick that completes sel+1 ticks
  always_comb begin
    evt    = run & tick & (div_q >= sel);
    div_en = clr | (run & tick);
    if (clr || evt) div_d = '0;
    else            div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end
endmodule

// File: rtl/msg_stamp_cnt.sv
module msg_stamp_cnt #(
  parameter int STAMP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               evt,
  output logic [STAMP_W-1:0] cnt
);
  logic [STAMP_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  // clear has priority; increment wraps naturally
  always_comb begin
    cnt_en = clr | evt;
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/msg_stamp_cap.sv
module msg_stamp_cap
  import msg_stamp_pkg::*;
#(
  parameter int STAMP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loopback,
  input  logic               tx_done,
  input  logic               rx_done,
  input  logic               slot_free,
  input  logic [STAMP_W-1:0] cnt,
  output logic               valid,
  output logic [STAMP_W-1:0] value
);
  cap_src_e           src;
  logic               take;
  logic               valid_q;
  logic [STAMP_W-1:0] value_q, value_d;

  always_comb begin
    src = cap_src_e'({rx_done, tx_done});
    if (loopback) take = (src == CAP_RX || src == CAP_BOTH) && slot_free;
    else          take = (src != CAP_NONE);
    value_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value_q <= '0;
    else if (take) value_q <= value_d;
  end

  assign valid = valid_q;
  assign value = value_q;
endmodule

// File: rtl/msg_stamp_timer.sv
module msg_stamp_timer
  import msg_stamp_pkg::*;
#(
  parameter int CNT_W = STAMP_W,
  parameter int PS_W  = SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic [PS_W-1:0]  pre_sel,
  input  logic [RST_W-1:0] mod_rst,
  input  logic             sw_clr,
  input  logic             loopback,
  input  logic             tx_done,
  input  logic             rx_done,
  input  logic             slot_free,
  output logic [CNT_W-1:0] stamp,
  output logic             cap_valid,
  output logic [CNT_W-1:0] cap_stamp
);
  logic run, clr, evt;

  assign run = (mod_rst == MODE_RUN);
  assign clr = sw_clr | (mod_rst == MODE_HALT);

  msg_stamp_presc #(.SEL_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr),
    .tick(bit_tick), .sel(pre_sel), .evt(evt)
  );

  msg_stamp_cnt #(.STAMP_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .evt(evt), .cnt(stamp)
  );

  msg_stamp_cap #(.STAMP_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .loopback(loopback),
    .tx_done(tx_done), .rx_done(rx_done), .slot_free(slot_free),
    .cnt(stamp), .valid(cap_valid), .value(cap_stamp)
  );
endmodule

// File: rtl/msg_stamp_timer_chk.sv
module msg_stamp_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic [1:0]       mod_rst,
  input logic             sw_clr,
  input logic             loopback,
  input logic             tx_done,
  input logic             rx_done,
  input logic             slot_free,
  input logic [CNT_W-1:0] stamp,
  input logic             cap_valid,
  input logic [CNT_W-1:0] cap_stamp
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_rst != 2'b00 && mod_rst != 2'b11 && !sw_clr) |=> $stable(stamp));

  assert_halt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_rst == 2'b11) |=> (stamp == '0));

  assert_sw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> (stamp == '0));

  // R2/R4: stamp only steps by one (with wrap) or returns to zero
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stamp == $past(stamp) || stamp == $past(stamp) + 1'b1 || stamp == '0));

  assert_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !sw_clr && mod_rst != 2'b11) |=> $stable(stamp));

  assert_normal_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!loopback && (tx_done || rx_done)) |=> (cap_valid && cap_stamp == $past(stamp)));

  assert_loop_filter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loopback && !(rx_done && slot_free)) |=> !cap_valid);

  assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_done && !rx_done) |=> !cap_valid);
endmodule

bind msg_stamp_timer msg_stamp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mod_rst(mod_rst),
  .sw_clr(sw_clr), .loopback(loopback), .tx_done(tx_done),
  .rx_done(rx_done), .slot_free(slot_free), .stamp(stamp),
  .cap_valid(cap_valid), .cap_stamp(cap_stamp)
);

// File: tb/msg_stamp_timer_test.sv
`timescale 1ns/1ps
module msg_stamp_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic [1:0]  pre_sel = 2'b00;
  logic [1:0]  mod_rst = 2'b11;
  logic        sw_clr = 1'b0;
  logic        loopback = 1'b0;
  logic        tx_done = 1'b0;
  logic        rx_done = 1'b0;
  logic        slot_free = 1'b0;
  logic [15:0] stamp, cap_stamp;
  logic        cap_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  int m_cnt = 0, m_div = 0, m_cs = 0;
  bit m_cv = 0;

  always #10 clk = ~clk;

  msg_stamp_timer uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .pre_sel(pre_sel),
    .mod_rst(mod_rst), .sw_clr(sw_clr), .loopback(loopback),
    .tx_done(tx_done), .rx_done(rx_done), .slot_free(slot_free),
    .stamp(stamp), .cap_valid(cap_valid), .cap_stamp(cap_stamp)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_cs = 0; m_cv = 0;
    end else begin
      if (loopback) m_cv = rx_done && slot_free;
      else          m_cv = tx_done || rx_done;
      if (m_cv) m_cs = m_cnt;
      if (mod_rst == 2'b11 || sw_clr) begin
        m_cnt = 0; m_div = 0;
      end else if (mod_rst == 2'b00 && bit_tick) begin
        if (m_div + 1 >= int'(pre_sel) + 1) begin
          m_div = 0;
          m_cnt = (m_cnt + 1) % 65536;
        end else m_div = m_div + 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(int'(stamp) == m_cnt, tag, "stamp vs model", stamp, m_cnt);
    chk(cap_valid == m_cv, tag, "cap_valid vs model", cap_valid, m_cv);
    if (m_cv) chk(int'(cap_stamp) == m_cs, tag, "cap_stamp vs model", cap_stamp, m_cs);
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_sw();
    sw_clr = 1'b1; cyc(1); sw_clr = 1'b0;
  endtask

  // count ticks from a clear until the first increment appears
  task automatic first_inc(input logic [1:0] sel, input int exp_ticks);
    int ticks;
    pre_sel = sel; bit_tick = 1'b0;
    clear_sw();
    ticks = 0;
    bit_tick = 1'b1;
    while (stamp == 16'd0 && ticks < 10) begin
      cyc(1);
      ticks++;
    end
    bit_tick = 1'b0;
    chk(ticks == exp_ticks, "R7", "ticks to first increment", ticks, exp_ticks);
  endtask

  task automatic cap_case(input bit lb, input bit tx, input bit rx, input bit sf,
                          input bit exp_v, input string req);
    logic [15:0] seen;
    loopback = lb; tx_done = tx; rx_done = rx; slot_free = sf;
    seen = stamp;
    cyc(1);
    tx_done = 1'b0; rx_done = 1'b0; slot_free = 1'b0;
    chk(cap_valid == exp_v, req, "capture pulse", cap_valid, exp_v);
    if (exp_v) chk(cap_stamp == seen, req, "captured stamp", cap_stamp, seen);
    cyc(1);
    chk(cap_valid == 1'b0, "R10", "pulse width one cycle", cap_valid, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    cyc(2);
    chk(stamp == 16'd0, "R1", "stamp in reset", stamp, 0);
    chk(cap_valid == 1'b0, "R1", "cap_valid in reset", cap_valid, 0);
    rst_n = 1'b1;
    cyc(1);
    mod_rst = 2'b00;
    cyc(1);
    chk(stamp == 16'd0, "R1", "stamp after reset", stamp, 0);

    // R2: each divisor, ticking every cycle
    tag = "R2";
    for (int s = 0; s < 4; s++) begin
      pre_sel = 2'(s);
      clear_sw();
      bit_tick = 1'b1;
      cyc(12 * (s + 1));
      bit_tick = 1'b0;
      cyc(1);
      chk(stamp == 16'd12, "R2", "count after 12 periods", stamp, 12);
    end
    // R2: sparse ticks
    pre_sel = 2'b01; clear_sw();
    for (int i = 0; i < 10; i++) begin
      bit_tick = 1'b1; cyc(1); bit_tick = 1'b0; cyc(2);
    end
    chk(stamp == 16'd5, "R2", "sparse ticks /2", stamp, 5);

    // R7
    tag = "R7";
    first_inc(2'b00, 1);
    first_inc(2'b10, 3);
    first_inc(2'b11, 4);

    // R3: hold with mixed reset bits
    tag = "R3";
    pre_sel = 2'b00; bit_tick = 1'b1; cyc(5);
    held = stamp;
    mod_rst = 2'b01; cyc(6);
    chk(stamp == held, "R3", "hold with 01", stamp, held);
    mod_rst = 2'b10; cyc(6);
    chk(stamp == held, "R3", "hold with 10", stamp, held);
    mod_rst = 2'b00; bit_tick = 1'b0; cyc(1);

    // R5
    tag = "R5";
    mod_rst = 2'b11; cyc(1);
    chk(stamp == 16'd0, "R5", "halt clears", stamp, 0);
    mod_rst = 2'b00; cyc(1);

    // R6: clear wins over count event
    tag = "R6";
    pre_sel = 2'b00; bit_tick = 1'b1; cyc(7);
    sw_clr = 1'b1; cyc(1); sw_clr = 1'b0; bit_tick = 1'b0;
    chk(stamp == 16'd0, "R6", "clear beats count", stamp, 0);
    cyc(1);

    // R8 / R9 / R10 captures
    tag = "R8";
    bit_tick = 1'b1; cyc(9);
    cap_case(0, 1, 0, 0, 1, "R8");
    cap_case(0, 0, 1, 0, 1, "R8");
    cap_case(0, 1, 1, 1, 1, "R8");
    tag = "R9";
    cap_case(1, 1, 0, 1, 0, "R9");
    cap_case(1, 0, 1, 0, 0, "R9");
    cap_case(1, 0, 1, 1, 1, "R9");
    cap_case(1, 1, 1, 1, 1, "R9");
    tag = "R10";
    loopback = 1'b0; tx_done = 1'b1; cyc(1); tx_done = 1'b0;
    chk(cap_valid == 1'b1, "R10", "pulse present", cap_valid, 1);
    cyc(1);
    chk(cap_valid == 1'b0, "R10", "pulse gone", cap_valid, 0);

    // R4: wrap
    tag = "R4";
    pre_sel = 2'b00; clear_sw(); bit_tick = 1'b1;
    cyc(65535);
    chk(stamp == 16'hFFFF, "R4", "reached max", stamp, 65535);
    cyc(1);
    chk(stamp == 16'h0000, "R4", "wrapped to zero", stamp, 0);
    cyc(1);
    chk(stamp == 16'h0001, "R4", "counting after wrap", stamp, 1);
    bit_tick = 1'b0;
    cyc(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule